// File: doc/BRIEF.md
# Dual-Channel Programmable Trigger Generator

The block drives two trigger outputs from one system clock. Each channel has two sources. The first is a free-running square wave whose high and low phase lengths are programmable. The second is a one-shot pulse of programmable width, started by its own enable. A per-channel select input chooses which source reaches the pin. All lengths are counted in system clock cycles, which is 10 ns each at 100 MHz.

Software or a neighbouring controller programs three 16-bit timing words per channel through a write-only port: an address, a data word and a one-cycle write strobe. A single run input starts and stops both square-wave generators together. Each pulse generator fires once for each rising edge on its own enable input.

Top module: `dual_trigger_gen`

## Requirements
- R1: While reset is asserted, and after it is released with every enable low, both trigger outputs are 0. All timing words reset to 0.
- R2: With the run input high and select 0, the output goes high at the first clock edge that samples run high. It then stays high for the high-length word and low for the low-length word, and repeats, counted in clock cycles.
- R3: A length word of 0 gives a phase, or a pulse, of exactly one cycle.
- R4: The run input is shared by both channels, so two channels started together rise in the same cycle. When run is sampled low, the square-wave output is 0 from the next edge. The next start begins again with a full high phase.
- R5: A rising edge sampled on a channel's pulse enable makes its pulse output high from the next edge for exactly the pulse-length word in cycles, with a 0 word counted as 1.
- R6: Holding the pulse enable high produces no further pulse. A new rising edge is needed.
- R7: A rising edge on the pulse enable while that channel's pulse is still high is ignored. The pulse keeps its length and no second pulse follows.
- R8: Select 0 routes the square wave to the channel output and select 1 routes the pulse. The source that is not selected has no effect on the output.
- R9: A timing word written while a generator is in a phase does not change that phase. The new value applies from the next phase that loads that word.
- R10: The write address is channel*4 + field, where field 0 is the high length, 1 the low length and 2 the pulse length. A write with field 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all lengths are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for a timing word |
| wr_addr | input | ADDR_W (3) | Word address: channel*4 + field |
| wr_data | input | CNT_W (16) | Timing word value |
| cont_en | input | 1 | Run input shared by both square-wave generators |
| pulse_en | input | NUM_CH (2) | Per-channel one-shot enable, acting on its rising edge |
| src_sel | input | NUM_CH (2) | Per-channel source select: 0 square wave, 1 pulse |
| trig_out | output | NUM_CH (2) | Trigger outputs |

## Verification
A table of timing sets is run through both sources on alternating channels. The sets are symmetric, strongly asymmetric, all zero, and single-cycle against long phases. Together they show whether the high and low words are swapped, whether a zero word is treated as one cycle, whether the pulse uses its own word, and whether a channel's address is decoded correctly. Directed cases then cover the rest: a write in the middle of a phase, re-triggering during a pulse, holding the enable high, stopping in the middle of a phase, starting both channels together, the reserved field, and an unselected source. These show whether a word is reloaded only at phase starts, whether the enable is edge-triggered, and whether the mux isolates the source that is not selected.

// File: rtl/trig_pkg.sv
package trig_pkg;

   // Low two address bits pick the timing word inside a channel's slot.
   localparam int unsigned FIELD_W = 2;

   typedef enum logic [FIELD_W-1:0] {
      FLD_HIGH  = 2'd0,
      FLD_LOW   = 2'd1,
      FLD_PULSE = 2'd2,
      FLD_RSVD  = 2'd3
   } field_e;

endpackage

// File: rtl/trig_regfile.sv
module trig_regfile #(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  hi_len [NUM_CH],
   output logic [CNT_W-1:0]  lo_len [NUM_CH],
   output logic [CNT_W-1:0]  ph_len [NUM_CH]
);
   import trig_pkg::*;

   localparam int unsigned SLOT_W = ADDR_W - FIELD_W;

   field_e             fld;
   logic [SLOT_W-1:0]  slot;

   assign fld  = field_e'(wr_addr[FIELD_W-1:0]);
   assign slot = wr_addr[ADDR_W-1:FIELD_W];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [SLOT_W-1:0] SLOT_ID = SLOT_W'(c);
      logic hit;
      assign hit = wr_en && (slot == SLOT_ID);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_len[c] <= '0;
            lo_len[c] <= '0;
            ph_len[c] <= '0;
         end else if (hit) begin
            unique case (fld)
               FLD_HIGH:  hi_len[c] <= wr_data;
               FLD_LOW:   lo_len[c] <= wr_data;
               FLD_PULSE: ph_len[c] <= wr_data;
               default:   ;
            endcase
         end
      end
   end

endmodule

// File: rtl/trig_cont_gen.sv
module trig_cont_gen #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [CNT_W-1:0] hi_len,
   input  logic [CNT_W-1:0] lo_len,
   output logic             out_q
);
   logic             started;
   logic [CNT_W-1:0] cnt;

   // Remaining-cycle load value; a zero word behaves as one cycle.
   function automatic logic [CNT_W-1:0] load_val(input logic [CNT_W-1:0] v);
      return (v == '0) ? '0 : v - 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         out_q   <= 1'b0;
         cnt     <= '0;
      end else if (!run_en) begin
         started <= 1'b0;
         out_q   <= 1'b0;
         cnt     <= '0;
      end else if (!started) begin
         started <= 1'b1;
         out_q   <= 1'b1;
         cnt     <= load_val(hi_len);
      end else if (cnt == '0) begin
         out_q <= ~out_q;
         cnt   <= out_q ? load_val(lo_len) : load_val(hi_len);
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_en,
   input  logic [CNT_W-1:0] ph_len,
   output logic             out_q
);
   logic             en_d;
   logic [CNT_W-1:0] cnt;
   logic             rise;

   assign rise = fire_en & ~en_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d  <= 1'b0;
         out_q <= 1'b0;
         cnt   <= '0;
      end else begin
         en_d <= fire_en;
         if (out_q) begin
            if (cnt == '0) out_q <= 1'b0;
            else           cnt   <= cnt - 1'b1;
         end else if (rise) begin
            out_q <= 1'b1;
            cnt   <= (ph_len == '0) ? '0 : ph_len - 1'b1;
         end
      end
   end

endmodule

// File: rtl/dual_trigger_gen.sv
module dual_trigger_gen #(
   parameter int unsigned NUM_CH  = 2,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned ADDR_W  = 3,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              cont_en,
   input  logic [NUM_CH-1:0] pulse_en,
   input  logic [NUM_CH-1:0] src_sel,
   output logic [NUM_CH-1:0] trig_out
);
   localparam int unsigned MIN_ADDR_W =
      trig_pkg::FIELD_W + ((NUM_CH > 1) ? $clog2(NUM_CH) : 1);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("dual_trigger_gen: NUM_CH must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("dual_trigger_gen: CNT_W must be at least 2");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("dual_trigger_gen: ADDR_W too narrow for NUM_CH");
   end

   logic [CNT_W-1:0]  hi_len [NUM_CH];
   logic [CNT_W-1:0]  lo_len [NUM_CH];
   logic [CNT_W-1:0]  ph_len [NUM_CH];
   logic [NUM_CH-1:0] cont_q;
   logic [NUM_CH-1:0] pulse_q;
   logic [NUM_CH-1:0] mux_d;

   trig_regfile #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .hi_len  (hi_len),
      .lo_len  (lo_len),
      .ph_len  (ph_len)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      trig_cont_gen #(.CNT_W(CNT_W)) u_cont (
         .clk    (clk),
         .rst_n  (rst_n),
         .run_en (cont_en),
         .hi_len (hi_len[c]),
         .lo_len (lo_len[c]),
         .out_q  (cont_q[c])
      );

      trig_pulse_gen #(.CNT_W(CNT_W)) u_pulse (
         .clk     (clk),
         .rst_n   (rst_n),
         .fire_en (pulse_en[c]),
         .ph_len  (ph_len[c]),
         .out_q   (pulse_q[c])
      );

      assign mux_d[c] = src_sel[c] ? pulse_q[c] : cont_q[c];
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) trig_out <= '0;
         else        trig_out <= mux_d;
      end
   end else begin : g_out_comb
      assign trig_out = mux_d;
   end

endmodule

// File: rtl/trig_gen_chk.sv
module trig_gen_chk #(
   parameter int unsigned NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cont_en,
   input logic [NUM_CH-1:0] pulse_en,
   input logic [NUM_CH-1:0] trig_out,
   input logic [NUM_CH-1:0] cont_q,
   input logic [NUM_CH-1:0] pulse_q
);

   // R1: outputs idle while reset is held
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (trig_out == '0))
      else $error("a_r1_reset_idle");

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R4: square wave is low the cycle after run is seen low
      a_r4_off_low: assert property (@(posedge clk) disable iff (!rst_n)
         !cont_en |=> !cont_q[c])
         else $error("a_r4_off_low ch%0d", c);

      // R2: square wave can only rise while run is high
      a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cont_q[c]) |-> $past(cont_en))
         else $error("a_r2_rise_needs_run ch%0d", c);

      // R5: a pulse starts only after its enable was sampled high
      a_r5_pulse_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pulse_q[c]) |-> $past(pulse_en[c]))
         else $error("a_r5_pulse_needs_en ch%0d", c);

      // R6: enable held high across the end of a pulse gives no new pulse
      a_r6_hold_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(pulse_q[c]) && pulse_en[c]) |=> !pulse_q[c])
         else $error("a_r6_hold_no_refire ch%0d", c);
   end

endmodule

bind dual_trigger_gen trig_gen_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cont_en  (cont_en),
   .pulse_en (pulse_en),
   .trig_out (trig_out),
   .cont_q   (cont_q),
   .pulse_q  (pulse_q)
);

// File: tb/dual_trigger_gen_tb.sv
module dual_trigger_gen_tb;
   localparam int NUM_CH = 2;
   localparam int CNT_W  = 16;
   localparam int ADDR_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic              cont_en = 1'b0;
   logic [NUM_CH-1:0] pulse_en = '0;
   logic [NUM_CH-1:0] src_sel = '0;
   logic [NUM_CH-1:0] trig_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5ns clk = ~clk;

   dual_trigger_gen #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cont_en(cont_en), .pulse_en(pulse_en),
      .src_sel(src_sel), .trig_out(trig_out)
   );

   // each entry: {high word, low word, pulse word}
   localparam logic [47:0] VEC [8] = '{
      {16'd4,  16'd4,  16'd6},
      {16'd7,  16'd2,  16'd3},
      {16'd0,  16'd0,  16'd0},
      {16'd1,  16'd12, 16'd1},
      {16'd15, 16'd1,  16'd9},
      {16'd2,  16'd9,  16'd0},
      {16'd3,  16'd5,  16'd17},
      {16'd1,  16'd1,  16'd2}
   };

   function automatic int eff(input logic [CNT_W-1:0] v);
      return (v == '0) ? 1 : int'(v);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      wr_en   = 1'b1;
      wr_addr = ADDR_W'(addr);
      wr_data = CNT_W'(data);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // counts consecutive negedge samples at the given level, current one included
   task automatic run_len(input int ch, input logic lvl, output int n);
      n = 0;
      while (trig_out[ch] == lvl && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int n;
      @(negedge clk);
      chk("R1 outputs in reset", int'(trig_out), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 outputs idle after reset", int'(trig_out), 0);

      // reset words are zero: one-cycle phases
      cont_en = 1'b1;
      @(negedge clk);
      run_len(0, 1'b1, n); chk("R1 R3 default high", n, 1);
      run_len(0, 1'b0, n); chk("R1 R3 default low", n, 1);
      cont_en = 1'b0;
      @(negedge clk);

      // table walk
      for (int i = 0; i < 8; i++) begin
         int ch, hi, lo, ph;
         ch = i % 2;
         hi = int'(VEC[i][47:32]);
         lo = int'(VEC[i][31:16]);
         ph = int'(VEC[i][15:0]);
         wr(ch*4 + 0, hi);
         wr(ch*4 + 1, lo);
         wr(ch*4 + 2, ph);
         src_sel[ch] = 1'b0;
         cont_en = 1'b1;
         @(negedge clk);
         run_len(ch, 1'b1, n); chk("R2 R10 high phase", n, eff(16'(hi)));
         run_len(ch, 1'b0, n); chk("R2 R10 low phase", n, eff(16'(lo)));
         run_len(ch, 1'b1, n); chk("R2 R3 repeat high", n, eff(16'(hi)));
         cont_en = 1'b0;
         @(negedge clk);
         chk("R4 stop low", int'(trig_out[ch]), 0);
         src_sel[ch] = 1'b1;
         pulse_en[ch] = 1'b1;
         @(negedge clk);
         run_len(ch, 1'b1, n); chk("R5 R3 pulse width", n, eff(16'(ph)));
         run_len(ch, 1'b0, n); chk("R6 held enable no refire", n, 2000);
         pulse_en[ch] = 1'b0;
         src_sel[ch] = 1'b0;
         @(negedge clk);
      end

      // R4: both channels start in the same cycle; stop mid-phase
      wr(0, 6); wr(1, 3); wr(4, 6); wr(5, 3);
      cont_en = 1'b1;
      @(negedge clk);
      chk("R4 shared start", int'(trig_out), 3);
      @(negedge clk);
      cont_en = 1'b0;
      @(negedge clk);
      chk("R4 stop mid-phase", int'(trig_out), 0);
      cont_en = 1'b1;
      @(negedge clk);
      run_len(0, 1'b1, n); chk("R4 restart full high", n, 6);
      cont_en = 1'b0;
      @(negedge clk);

      // R9: write during a high phase
      wr(0, 8); wr(1, 8);
      cont_en = 1'b1;
      @(negedge clk);
      wr(0, 3);
      run_len(0, 1'b1, n); chk("R9 phase unchanged by write", n + 1, 8);
      run_len(0, 1'b0, n); chk("R9 low phase", n, 8);
      run_len(0, 1'b1, n); chk("R9 new high applies", n, 3);
      cont_en = 1'b0;
      @(negedge clk);

      // R7: new edge during a pulse is ignored
      wr(2, 10);
      src_sel[0] = 1'b1;
      pulse_en[0] = 1'b1;
      @(negedge clk);
      pulse_en[0] = 1'b0;
      @(negedge clk);
      pulse_en[0] = 1'b1;
      @(negedge clk);
      run_len(0, 1'b1, n); chk("R7 pulse width kept", n + 2, 10);
      run_len(0, 1'b0, n); chk("R7 no second pulse", n, 2000);
      pulse_en[0] = 1'b0;
      @(negedge clk);

      // R10: reserved field; ch1 high word does not touch ch0
      wr(0, 5); wr(1, 5);
      wr(3, 2);
      wr(4, 2);
      src_sel = 2'b00;
      cont_en = 1'b1;
      @(negedge clk);
      run_len(0, 1'b1, n); chk("R10 reserved field ignored", n, 5);
      cont_en = 1'b0;
      @(negedge clk);
      cont_en = 1'b1;
      @(negedge clk);
      run_len(1, 1'b1, n); chk("R10 ch1 high word", n, 2);
      cont_en = 1'b0;
      @(negedge clk);

      // R8: the source that is not selected has no effect
      wr(2, 4);
      src_sel[0] = 1'b0;
      pulse_en[0] = 1'b1;
      @(negedge clk);
      chk("R8 pulse hidden by select 0", int'(trig_out[0]), 0);
      pulse_en[0] = 1'b0;
      repeat (6) @(negedge clk);
      src_sel[0] = 1'b1;
      cont_en = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 square wave hidden by select 1", int'(trig_out[0]), 0);
      cont_en = 1'b0;
      @(negedge clk);

      summary();
      $finish;
   end

endmodule